// File: doc/BRIEF.md
# Root Hub Downstream Port Status and Control Register

This block holds the status and control register for one downstream port of a USB host controller's root hub. Host software controls the port by writing ones. Each low-order bit carries a command on write and a different status field on read. The commands are set enable, clear enable, set suspend, clear suspend (which starts a resume) and set reset. A read returns the live status: device connected, port enabled, suspended, overcurrent and reset active. The same word also carries five change flags, which software clears by writing ones to them.

The hardware side drives the block with several inputs: a connect level, an overcurrent level, a bus-error pulse, a power-off pulse, and two one-cycle pulses from external timers that mark the end of reset signalling and the end of the resume interval. If software aims a state-changing command at a port with nothing attached, the target bit stays as it was and the connect change flag is raised instead. This tells the driver that it addressed an empty port. Two parameters control the connect and overcurrent fields. One marks the port as non-removable, so connect always reads one. The other turns off per-port overcurrent reporting, so the overcurrent field reads zero.

Top module: `rh_port_reg`

## Requirements
- R1: After reset every status bit and change flag reads zero (apart from connect on a non-removable port).
- R2: The read word carries connect at bit 0, enabled at bit 1, suspended at bit 2, overcurrent at bit 3 and reset active at bit 4. The change flags for connect, enable, suspend, overcurrent and reset sit at bits 16, 17, 18, 19 and 20.
- R3: A write of zero to any bit has no effect on any field.
- R4: When connect reads zero, writing one to bit 1 (set enable), bit 2 (set suspend) or bit 4 (set reset) leaves the target bit unchanged and sets the connect change flag.
- R5: Writing one to bit 1 sets enabled if a device is connected. Writing one to bit 0 clears enabled. Enabled never reads one while connect reads zero.
- R6: Writing one to bit 4 on a connected port makes reset active, and the reset output stays high until the reset-done pulse. On that pulse, reset active clears, the reset change flag sets, the port becomes enabled and suspended clears, all in the same cycle.
- R7: Writing one to bit 3 starts a resume only when the port is suspended. Suspended stays one during the resume and clears on the resume-done pulse, at the same time as the suspend change flag sets.
- R8: Overcurrent, a bus error, power off or a disconnect clears enabled and, if the port was enabled, sets the enable change flag. This clearing wins over a set-enable write or a reset completion in the same cycle.
- R9: Each rising or falling edge of the connect input sets the connect change flag one cycle later. No write ever changes connect.
- R10: With per-port reporting on, the overcurrent bit follows the overcurrent input one cycle later, and every change of it sets the overcurrent change flag.
- R11: Writing one to a change flag clears it. A hardware set in the same cycle as the clear wins.
- R12: A port with the non-removable option reads connect as one. With per-port overcurrent reporting off, the overcurrent bit reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wdata | input | DATA_W | Write data (commands and flag clears) |
| rdata | output | DATA_W | Live status and change flags |
| conn_in | input | 1 | Device-present level from the line monitor |
| oc_in | input | 1 | Overcurrent level for this port |
| bus_err | input | 1 | Operational bus error pulse |
| pwr_off | input | 1 | Port power switched off pulse |
| rst_done | input | 1 | One-cycle pulse: reset signalling finished |
| rsm_done | input | 1 | One-cycle pulse: resume interval finished |
| port_reset_o | output | 1 | Request reset signalling on the line |
| port_resume_o | output | 1 | Request resume signalling on the line |

## Verification
Two collisions matter most. The first is a hardware disable landing in the same cycle as a reset completion or a set-enable write. The bench provokes it by driving a bus-error pulse together with the reset-done pulse, and again together with a set-enable write. It expects enabled to read zero, with the reset change flag still set. The second is a flag-clearing write landing in the same cycle as a disconnect edge. There the connect and enable change flags must both read one afterwards, because the hardware set takes precedence over the software clear.

// File: rtl/rh_port_pkg.sv
package rh_port_pkg;
   // status field positions on read; same positions carry commands on write
   localparam int unsigned ST_CONN = 0;
   localparam int unsigned ST_EN   = 1;
   localparam int unsigned ST_SUSP = 2;
   localparam int unsigned ST_OC   = 3;
   localparam int unsigned ST_RST  = 4;
   localparam int unsigned N_FIELD = 5;

   // change flag indices (offset from the flag base)
   localparam int unsigned CH_CONN = 0;
   localparam int unsigned CH_EN   = 1;
   localparam int unsigned CH_SUSP = 2;
   localparam int unsigned CH_OC   = 3;
   localparam int unsigned CH_RST  = 4;
   localparam int unsigned N_CHG   = 5;

   typedef struct packed {
      logic clr_en;
      logic set_en;
      logic set_susp;
      logic clr_susp;
      logic set_rst;
   } port_cmd_t;
endpackage

// File: rtl/rh_port_cmd.sv
module rh_port_cmd
   import rh_port_pkg::*;
(
   input  logic               wr_en,
   input  logic [N_FIELD-1:0] cmd_bits,
   input  logic [N_CHG-1:0]   clr_bits,
   output port_cmd_t          cmd,
   output logic [N_CHG-1:0]   chg_clr
);
   always_comb begin
      cmd.clr_en   = wr_en & cmd_bits[ST_CONN];
      cmd.set_en   = wr_en & cmd_bits[ST_EN];
      cmd.set_susp = wr_en & cmd_bits[ST_SUSP];
      cmd.clr_susp = wr_en & cmd_bits[ST_OC];
      cmd.set_rst  = wr_en & cmd_bits[ST_RST];
   end

   assign chg_clr = {N_CHG{wr_en}} & clr_bits;
endmodule

// File: rtl/rh_port_state.sv
module rh_port_state
   import rh_port_pkg::*;
#(
   parameter bit NON_REMOVABLE = 1'b0,
   parameter bit PORT_OC_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  port_cmd_t        cmd,
   input  logic             conn_in,
   input  logic             oc_in,
   input  logic             bus_err,
   input  logic             pwr_off,
   input  logic             rst_done,
   input  logic             rsm_done,
   output logic             conn,
   output logic             pes,
   output logic             pss,
   output logic             poc,
   output logic             prs,
   output logic             resuming,
   output logic [N_CHG-1:0] chg_set
);
   logic conn_q, oc_q;
   logic pes_d, pss_d, prs_d, rsm_d;
   logic conn_nxt, conn_edge, oc_edge, hw_off;

   generate
      if (NON_REMOVABLE) begin : g_fixed
         assign conn      = 1'b1;
         assign conn_nxt  = 1'b1;
         assign conn_edge = 1'b0;
      end else begin : g_removable
         assign conn      = conn_q;
         assign conn_nxt  = conn_in;
         assign conn_edge = conn_in ^ conn_q;
      end
      if (PORT_OC_EN) begin : g_oc_rep
         assign poc     = oc_q;
         assign oc_edge = oc_in ^ oc_q;
      end else begin : g_oc_off
         assign poc     = 1'b0;
         assign oc_edge = 1'b0;
      end
   endgenerate

   assign hw_off = oc_in | bus_err | pwr_off | ~conn_nxt;

   always_comb begin
      pes_d   = pes;
      pss_d   = pss;
      prs_d   = prs;
      rsm_d   = resuming;
      chg_set = '0;
      if (cmd.clr_en) pes_d = 1'b0;
      if (cmd.set_en) begin
         if (conn) pes_d = 1'b1;
         else      chg_set[CH_CONN] = 1'b1;
      end
      if (cmd.set_susp) begin
         if (conn) pss_d = 1'b1;
         else      chg_set[CH_CONN] = 1'b1;
      end
      if (cmd.clr_susp && pss) rsm_d = 1'b1;
      if (cmd.set_rst) begin
         if (conn) prs_d = 1'b1;
         else      chg_set[CH_CONN] = 1'b1;
      end
      if (resuming && rsm_done) begin
         pss_d = 1'b0;
         rsm_d = 1'b0;
         chg_set[CH_SUSP] = 1'b1;
      end
      if (prs && rst_done) begin
         prs_d = 1'b0;
         pes_d = 1'b1;
         pss_d = 1'b0;
         rsm_d = 1'b0;
         chg_set[CH_RST] = 1'b1;
      end
      // hardware disable overrides any enable from software or reset
      if (hw_off) begin
         pes_d = 1'b0;
         if (pes) chg_set[CH_EN] = 1'b1;
      end
      if (conn_edge) chg_set[CH_CONN] = 1'b1;
      if (oc_edge)   chg_set[CH_OC]   = 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         conn_q   <= 1'b0;
         oc_q     <= 1'b0;
         pes      <= 1'b0;
         pss      <= 1'b0;
         prs      <= 1'b0;
         resuming <= 1'b0;
      end else begin
         conn_q   <= conn_in;
         oc_q     <= oc_in;
         pes      <= pes_d;
         pss      <= pss_d;
         prs      <= prs_d;
         resuming <= rsm_d;
      end
   end

   // R5: enabled never seen without a connected device
   p_en_needs_conn_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pes |-> conn);

   // R7: resume in progress only while suspended
   p_resume_in_susp_r7: assert property (@(posedge clk) disable iff (!rst_n)
      resuming |-> pss);
endmodule

// File: rtl/rh_port_chg.sv
module rh_port_chg
   import rh_port_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_CHG-1:0] set_i,
   input  logic [N_CHG-1:0] clr_i,
   output logic [N_CHG-1:0] flags
);
   genvar gi;
   generate
      for (gi = 0; gi < N_CHG; gi++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n)          flags[gi] <= 1'b0;
            else if (set_i[gi])  flags[gi] <= 1'b1;
            else if (clr_i[gi])  flags[gi] <= 1'b0;
         end
      end
   endgenerate

   // R11: a hardware set is never lost to a same-cycle clear
   p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (set_i != '0) |=> ((flags & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/rh_port_reg.sv
module rh_port_reg
   import rh_port_pkg::*;
#(
   parameter int unsigned DATA_W        = 32,
   parameter int unsigned CHG_LSB       = 16,
   parameter bit          NON_REMOVABLE = 1'b0,
   parameter bit          PORT_OC_EN    = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata,
   input  logic              conn_in,
   input  logic              oc_in,
   input  logic              bus_err,
   input  logic              pwr_off,
   input  logic              rst_done,
   input  logic              rsm_done,
   output logic              port_reset_o,
   output logic              port_resume_o
);
   localparam int unsigned CHG_MSB = CHG_LSB + N_CHG - 1;

   generate
      if (CHG_LSB < N_FIELD || CHG_MSB >= DATA_W) begin : g_bad_layout
         $error("change flag field does not fit the data word");
      end
   endgenerate

   port_cmd_t        cmd;
   logic [N_CHG-1:0] chg_clr, chg_set, flags;
   logic             conn, pes, pss, poc, prs, resuming;

   rh_port_cmd u_cmd (
      .wr_en    (wr_en),
      .cmd_bits (wdata[N_FIELD-1:0]),
      .clr_bits (wdata[CHG_MSB:CHG_LSB]),
      .cmd      (cmd),
      .chg_clr  (chg_clr)
   );

   rh_port_state #(
      .NON_REMOVABLE (NON_REMOVABLE),
      .PORT_OC_EN    (PORT_OC_EN)
   ) u_state (
      .clk      (clk),
      .rst_n    (rst_n),
      .cmd      (cmd),
      .conn_in  (conn_in),
      .oc_in    (oc_in),
      .bus_err  (bus_err),
      .pwr_off  (pwr_off),
      .rst_done (rst_done),
      .rsm_done (rsm_done),
      .conn     (conn),
      .pes      (pes),
      .pss      (pss),
      .poc      (poc),
      .prs      (prs),
      .resuming (resuming),
      .chg_set  (chg_set)
   );

   rh_port_chg u_chg (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (chg_set),
      .clr_i (chg_clr),
      .flags (flags)
   );

   always_comb begin
      rdata                   = '0;
      rdata[ST_CONN]          = conn;
      rdata[ST_EN]            = pes;
      rdata[ST_SUSP]          = pss;
      rdata[ST_OC]            = poc;
      rdata[ST_RST]           = prs;
      rdata[CHG_MSB:CHG_LSB]  = flags;
   end

   assign port_reset_o  = prs;
   assign port_resume_o = resuming;

   // R4: a state command to an empty port raises the connect change flag
   p_cmd_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (wdata[ST_EN] || wdata[ST_SUSP] || wdata[ST_RST]) && !conn)
      |=> flags[CH_CONN]);

   // R6: reset active ends only together with the reset change flag
   p_rst_end_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(prs) |-> flags[CH_RST]);

   // R7: suspended clears only at resume end or reset end
   p_susp_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(pss) |-> (flags[CH_SUSP] || flags[CH_RST]));

   // R8: a hardware disable source leaves the port disabled next cycle
   p_hw_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_err || pwr_off || oc_in) |=> !pes);
endmodule

// File: tb/rh_port_reg_tb.sv
module rh_port_reg_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wdata = '0;
   logic        conn_in = 1'b0, oc_in = 1'b0, bus_err = 1'b0, pwr_off = 1'b0;
   logic        rst_done = 1'b0, rsm_done = 1'b0;
   logic [31:0] rdata, rdata_fix;
   logic        port_reset_o, port_resume_o, fix_rst, fix_rsm;
   int          checks = 0, errors = 0;
   bit          done = 1'b0;

   localparam logic [31:0] CSC = 32'h1 << 16, PESC = 32'h1 << 17, PSSC = 32'h1 << 18;
   localparam logic [31:0] OCIC = 32'h1 << 19, PRSC = 32'h1 << 20, ALLCHG = 32'h1F << 16;

   always #10 clk = ~clk;

   rh_port_reg u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
      .conn_in(conn_in), .oc_in(oc_in), .bus_err(bus_err), .pwr_off(pwr_off),
      .rst_done(rst_done), .rsm_done(rsm_done),
      .port_reset_o(port_reset_o), .port_resume_o(port_resume_o));

   rh_port_reg #(.NON_REMOVABLE(1'b1), .PORT_OC_EN(1'b0)) u_fix (
      .clk(clk), .rst_n(rst_n), .wr_en(1'b0), .wdata(32'h0), .rdata(rdata_fix),
      .conn_in(conn_in), .oc_in(oc_in), .bus_err(bus_err), .pwr_off(pwr_off),
      .rst_done(rst_done), .rsm_done(rsm_done),
      .port_reset_o(fix_rst), .port_resume_o(fix_rsm));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(logic [31:0] d);
      @(negedge clk); wr_en = 1'b1; wdata = d;
      @(negedge clk); wr_en = 1'b0; wdata = '0;
   endtask

   task automatic t_reset_state;
      chk("R1 reset state", rdata, 32'h0);
      chk("R12 fixed port reset", rdata_fix, 32'h1);
      wr(32'h0);
      chk("R3 zero write", rdata, 32'h0);
   endtask

   task automatic t_empty_port;
      wr(32'h2);
      chk("R4 set enable empty", rdata, CSC);
      wr(ALLCHG);
      chk("R11 flag clear", rdata, 32'h0);
      wr(32'h10);
      chk("R4 set reset empty", rdata, CSC);
      wr(32'h4 | CSC);
      chk("R4 set suspend empty", rdata, CSC);
      wr(ALLCHG);
   endtask

   task automatic t_connect;
      @(negedge clk); conn_in = 1'b1;
      @(negedge clk);
      chk("R9 connect edge", rdata, 32'h1 | CSC);
      wr(CSC);
      wr(32'h1);
      chk("R9 write keeps connect", rdata, 32'h1);
      wr(32'h2);
      chk("R5 set enable", rdata, 32'h3);
      wr(32'h1);
      chk("R5 clear enable", rdata, 32'h1);
   endtask

   task automatic t_port_reset;
      wr(32'h2); wr(32'h4);
      chk("R2 enabled and suspended", rdata, 32'h7);
      wr(32'h10);
      chk("R6 reset active", rdata, 32'h17);
      chk("R6 reset output", {31'h0, port_reset_o}, 32'h1);
      @(negedge clk); rst_done = 1'b1;
      @(negedge clk); rst_done = 1'b0;
      chk("R6 reset complete", rdata, 32'h3 | PRSC);
      wr(ALLCHG);
   endtask

   task automatic t_resume;
      wr(32'h8);
      chk("R7 resume ignored not suspended", {rdata[15:0], 15'h0, port_resume_o}, {16'h3, 16'h0});
      wr(32'h4);
      wr(32'h8);
      chk("R7 resume running", {rdata[15:0], 15'h0, port_resume_o}, {16'h7, 16'h1});
      @(negedge clk); rsm_done = 1'b1;
      @(negedge clk); rsm_done = 1'b0;
      chk("R7 resume done", rdata, 32'h3 | PSSC);
      wr(ALLCHG);
   endtask

   task automatic t_hw_disable;
      @(negedge clk); bus_err = 1'b1;
      @(negedge clk); bus_err = 1'b0;
      chk("R8 bus error disables", rdata, 32'h1 | PESC);
      wr(ALLCHG); wr(32'h2);
      @(negedge clk); pwr_off = 1'b1;
      @(negedge clk); pwr_off = 1'b0;
      chk("R8 power off disables", rdata, 32'h1 | PESC);
      wr(ALLCHG); wr(32'h2); wr(32'h10);
      @(negedge clk); rst_done = 1'b1; bus_err = 1'b1;
      @(negedge clk); rst_done = 1'b0; bus_err = 1'b0;
      chk("R8 disable beats reset completion", rdata, 32'h1 | PESC | PRSC);
      wr(ALLCHG);
      @(negedge clk); wr_en = 1'b1; wdata = 32'h2; bus_err = 1'b1;
      @(negedge clk); wr_en = 1'b0; wdata = '0; bus_err = 1'b0;
      chk("R8 disable beats set enable", rdata, 32'h1);
   endtask

   task automatic t_overcurrent;
      wr(32'h2);
      @(negedge clk); oc_in = 1'b1;
      @(negedge clk);
      chk("R10 overcurrent rise", rdata, 32'h9 | PESC | OCIC);
      chk("R12 overcurrent masked", rdata_fix, 32'h1);
      wr(ALLCHG);
      chk("R10 overcurrent held", rdata, 32'h9);
      @(negedge clk); oc_in = 1'b0;
      @(negedge clk);
      chk("R10 overcurrent fall", rdata, 32'h1 | OCIC);
      wr(ALLCHG);
   endtask

   task automatic t_clear_collision;
      wr(32'h2);
      @(negedge clk); wr_en = 1'b1; wdata = ALLCHG; conn_in = 1'b0;
      @(negedge clk); wr_en = 1'b0; wdata = '0;
      chk("R11 set wins over clear", rdata, CSC | PESC);
      wr(32'h2);
      chk("R5 no enable when empty", rdata[1:0], 2'b00);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset_state();
      t_empty_port();
      t_connect();
      t_port_reset();
      t_resume();
      t_hw_disable();
      t_overcurrent();
      t_clear_collision();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule